// File: doc/BRIEF.md
# Block Longitudinal Redundancy Checker

This unit keeps an 8-bit running XOR over the characters of a block-mode smart-card exchange. Each character strobed in on the receive side or sent out on the transmit side is folded into one accumulator, but only while the unit is switched on. When a received block ends, the unit tests the accumulator for zero. A zero result sets a registered check-good flag that software can read.

On the transmit side the unit watches a FIFO-empty signal. When the FIFO drains and auto-append is selected, the unit offers the accumulated value as one extra character over a valid/ready handshake. The offer is made exactly once for each time the FIFO becomes empty. The check byte is not folded back into the accumulator.

The accumulator returns to zero on any of these events:
- the unit is switched off;
- a transmission ends, which is either the accepted check byte, or the FIFO draining while auto-append is off;
- the transmitter enable rises.

Each of these clears wins over a character strobe in the same cycle.

Top module: `lrc_engine`

## Requirements
- R1: Each cycle in which the unit is on, the accumulator takes its previous value XOR the receive character (if `rx_char_stb`) XOR the transmit character (if `tx_char_stb`). Both strobes in one cycle fold both characters.
- R2: While `cfg_on` is low, `lrc_value` is 0 one cycle later and stays 0. Character strobes and `rx_block_end` have no effect.
- R3: When `rx_block_end` is high and the unit is on, `rx_good` on the next cycle is 1 if the accumulator XOR any same-cycle strobed characters equals 0x00, and 0 otherwise.
- R4: `rx_block_start` or `sw_clr_good` clears `rx_good` on the next cycle. An evaluating `rx_block_end` in the same cycle takes precedence.
- R5: A rising edge of `fifo_empty` with `cfg_on` and `cfg_append` high raises `chk_valid` on the next cycle. `chk_data` then equals the accumulator including any same-cycle transmit character. Both are held unchanged until `chk_ready` is sampled high.
- R6: The cycle after `chk_valid` and `chk_ready` are both high, `chk_valid` is 0 and `lrc_value` is 0. The byte is offered only once per rising edge of `fifo_empty`.
- R7: A rising edge of `fifo_empty` with `cfg_append` low clears `lrc_value` on the next cycle, and no offer is made.
- R8: A rising edge of `tx_en` clears `lrc_value` on the next cycle.
- R9: Any clear event (switch-off, end of transmission, `tx_en` rise) takes priority over character strobes in the same cycle.
- R10: Synchronous active-high `rst` drives `lrc_value`, `chk_valid` and `rx_good` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_on | input | 1 | Unit enable; low clears and holds the accumulator |
| cfg_append | input | 1 | Append the check byte when the FIFO drains |
| tx_en | input | 1 | Transmitter enable level; its rising edge clears |
| rx_char_stb | input | 1 | Received character valid |
| rx_char | input | DATA_W | Received character |
| rx_block_start | input | 1 | Start of a received block; clears `rx_good` |
| rx_block_end | input | 1 | End of a received block; evaluates the check |
| sw_clr_good | input | 1 | Software write-1-to-clear of `rx_good` |
| tx_char_stb | input | 1 | Transmitted character valid |
| tx_char | input | DATA_W | Transmitted character |
| fifo_empty | input | 1 | Transmit FIFO empty level |
| chk_ready | input | 1 | Transmitter accepts the check byte |
| chk_valid | output | 1 | Check byte offered |
| chk_data | output | DATA_W | Check byte value |
| rx_good | output | 1 | Received block checked as zero |
| lrc_value | output | DATA_W | Current accumulator |

## Verification
All outputs are registers. Every result therefore appears one rising edge after the cycle that holds its stimulus. This covers the folded accumulator, the cleared value, the raised offer, the dropped offer after a handshake and the check-good flag. The bench drives inputs just after a falling edge, waits for the next falling edge and samples there. That sample point lies half a period after the single rising edge on which the result is due, and single-cycle strobes are withdrawn immediately after it. Held conditions such as a pending offer are checked again on later falling edges to confirm they persist.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic {
    APP_IDLE  = 1'b0,
    APP_OFFER = 1'b1
  } app_st_e;

  localparam int LANES = 2;
endpackage

// File: rtl/lrc_accum.sv
module lrc_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         on,
  input  logic         tx_en,
  input  logic         end_clr,
  input  logic         rx_stb,
  input  logic [W-1:0] rx_dat,
  input  logic         tx_stb,
  input  logic [W-1:0] tx_dat,
  output logic [W-1:0] acc,
  output logic [W-1:0] acc_fold
);
  localparam int NL = lrc_pkg::LANES;

  logic [NL-1:0] stb;
  logic [W-1:0]  dat [NL];
  logic [W-1:0]  msk [NL];
  logic          ten_q;
  logic          clr_evt;

  assign stb    = {tx_stb, rx_stb};
  assign dat[0] = rx_dat;
  assign dat[1] = tx_dat;

  // one masking lane per character source
  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_lane
      assign msk[g] = stb[g] ? dat[g] : '0;
    end
  endgenerate

  always_comb begin
    acc_fold = acc;
    for (int i = 0; i < NL; i++) acc_fold = acc_fold ^ msk[i];
  end

  always_ff @(posedge clk) begin
    if (rst) ten_q <= 1'b0;
    else     ten_q <= tx_en;
  end

  // clears outrank character strobes
  assign clr_evt = !on || (tx_en && !ten_q) || end_clr;

  always_ff @(posedge clk) begin
    if (rst)          acc <= '0;
    else if (clr_evt) acc <= '0;
    else              acc <= acc_fold;
  end
endmodule

// File: rtl/lrc_append.sv
module lrc_append #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         on,
  input  logic         append,
  input  logic         fifo_empty,
  input  logic         ready,
  input  logic [W-1:0] fold,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         end_clr
);
  lrc_pkg::app_st_e st;
  logic fe_q;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) fe_q <= 1'b1;
    else     fe_q <= fifo_empty;
  end

  assign rise = on && fifo_empty && !fe_q;

  assign end_clr = (rise && !append && st == lrc_pkg::APP_IDLE) ||
                   (st == lrc_pkg::APP_OFFER && ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= lrc_pkg::APP_IDLE;
      data <= '0;
    end else if (!on) begin
      st <= lrc_pkg::APP_IDLE;
    end else begin
      unique case (st)
        lrc_pkg::APP_IDLE: begin
          if (rise && append) begin
            st   <= lrc_pkg::APP_OFFER;
            data <= fold;
          end
        end
        lrc_pkg::APP_OFFER: begin
          if (ready) st <= lrc_pkg::APP_IDLE;
        end
        default: st <= lrc_pkg::APP_IDLE;
      endcase
    end
  end

  assign valid = (st == lrc_pkg::APP_OFFER);
endmodule

// File: rtl/lrc_rxstat.sv
module lrc_rxstat #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         on,
  input  logic         blk_start,
  input  logic         blk_end,
  input  logic         sw_clr,
  input  logic [W-1:0] fold,
  output logic         good
);
  always_ff @(posedge clk) begin
    if (rst)                     good <= 1'b0;
    else if (on && blk_end)      good <= (fold == '0);
    else if (blk_start || sw_clr) good <= 1'b0;
  end
endmodule

// File: rtl/lrc_engine.sv
module lrc_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_on,
  input  logic              cfg_append,
  input  logic              tx_en,
  input  logic              rx_char_stb,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              rx_block_start,
  input  logic              rx_block_end,
  input  logic              sw_clr_good,
  input  logic              tx_char_stb,
  input  logic [DATA_W-1:0] tx_char,
  input  logic              fifo_empty,
  input  logic              chk_ready,
  output logic              chk_valid,
  output logic [DATA_W-1:0] chk_data,
  output logic              rx_good,
  output logic [DATA_W-1:0] lrc_value
);
  logic [DATA_W-1:0] w_fold;
  logic              w_end_clr;

  lrc_accum #(.W(DATA_W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .on       (cfg_on),
    .tx_en    (tx_en),
    .end_clr  (w_end_clr),
    .rx_stb   (rx_char_stb),
    .rx_dat   (rx_char),
    .tx_stb   (tx_char_stb),
    .tx_dat   (tx_char),
    .acc      (lrc_value),
    .acc_fold (w_fold)
  );

  lrc_append #(.W(DATA_W)) u_append (
    .clk        (clk),
    .rst        (rst),
    .on         (cfg_on),
    .append     (cfg_append),
    .fifo_empty (fifo_empty),
    .ready      (chk_ready),
    .fold       (w_fold),
    .valid      (chk_valid),
    .data       (chk_data),
    .end_clr    (w_end_clr)
  );

  lrc_rxstat #(.W(DATA_W)) u_rxstat (
    .clk       (clk),
    .rst       (rst),
    .on        (cfg_on),
    .blk_start (rx_block_start),
    .blk_end   (rx_block_end),
    .sw_clr    (sw_clr_good),
    .fold      (w_fold),
    .good      (rx_good)
  );
endmodule

// File: rtl/lrc_engine_chk.sv
module lrc_engine_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_on,
  input logic         tx_en,
  input logic         rx_char_stb,
  input logic [W-1:0] rx_char,
  input logic         tx_char_stb,
  input logic         rx_block_start,
  input logic         rx_block_end,
  input logic         chk_ready,
  input logic         chk_valid,
  input logic [W-1:0] chk_data,
  input logic         rx_good,
  input logic [W-1:0] lrc_value,
  input logic         end_clr
);
  logic ten_q;
  always_ff @(posedge clk) begin
    if (rst) ten_q <= 1'b0;
    else     ten_q <= tx_en;
  end

  p_off_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_on |=> lrc_value == '0);

  p_rx_fold_r1: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && rx_char_stb && !tx_char_stb && !(tx_en && !ten_q) && !end_clr)
      |=> lrc_value == $past(lrc_value ^ rx_char));

  p_txen_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !ten_q) |=> lrc_value == '0);

  p_offer_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && chk_valid && !chk_ready) |=> (chk_valid && $stable(chk_data)));

  p_handshake_r6: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_ready) |=> (!chk_valid && lrc_value == '0));

  p_good_set_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_on && rx_block_end && !rx_char_stb && !tx_char_stb && lrc_value == '0)
      |=> rx_good);

  p_start_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_block_start && !(cfg_on && rx_block_end)) |=> !rx_good);
endmodule

bind lrc_engine lrc_engine_chk #(.W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_on         (cfg_on),
  .tx_en          (tx_en),
  .rx_char_stb    (rx_char_stb),
  .rx_char        (rx_char),
  .tx_char_stb    (tx_char_stb),
  .rx_block_start (rx_block_start),
  .rx_block_end   (rx_block_end),
  .chk_ready      (chk_ready),
  .chk_valid      (chk_valid),
  .chk_data       (chk_data),
  .rx_good        (rx_good),
  .lrc_value      (lrc_value),
  .end_clr        (w_end_clr)
);

// File: tb/lrc_engine_bench.sv
`timescale 1ns/1ps
module lrc_engine_bench;
  logic       clk = 1'b0;
  logic       rst, cfg_on, cfg_append, tx_en;
  logic       rx_char_stb, rx_block_start, rx_block_end, sw_clr_good;
  logic       tx_char_stb, fifo_empty, chk_ready;
  logic [7:0] rx_char, tx_char;
  logic       chk_valid, rx_good;
  logic [7:0] chk_data, lrc_value;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  logic [7:0] exp_acc;

  always #10 clk = ~clk;

  lrc_engine u_lrc_engine (
    .clk(clk), .rst(rst), .cfg_on(cfg_on), .cfg_append(cfg_append), .tx_en(tx_en),
    .rx_char_stb(rx_char_stb), .rx_char(rx_char), .rx_block_start(rx_block_start),
    .rx_block_end(rx_block_end), .sw_clr_good(sw_clr_good), .tx_char_stb(tx_char_stb),
    .tx_char(tx_char), .fifo_empty(fifo_empty), .chk_ready(chk_ready),
    .chk_valid(chk_valid), .chk_data(chk_data), .rx_good(rx_good), .lrc_value(lrc_value)
  );

  // {rx_stb, rx_char, tx_stb, tx_char}
  localparam logic [17:0] VEC [0:5] = '{
    {1'b1, 8'h3C, 1'b0, 8'h00},
    {1'b0, 8'hFF, 1'b1, 8'hA1},
    {1'b1, 8'h0F, 1'b1, 8'hF0},
    {1'b0, 8'h77, 1'b0, 8'h88},
    {1'b1, 8'h80, 1'b0, 8'h00},
    {1'b1, 8'h5A, 1'b1, 8'h5A}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic quiet();
    rx_char_stb = 0; tx_char_stb = 0; rx_block_start = 0;
    rx_block_end = 0; sw_clr_good = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg_on = 0; cfg_append = 0; tx_en = 0; fifo_empty = 1; chk_ready = 0;
    rx_char = 0; tx_char = 0; quiet();
    repeat (3) cyc();
    check("R10 reset lrc_value", lrc_value, 0);
    check("R10 reset chk_valid", chk_valid, 0);
    check("R10 reset rx_good", rx_good, 0);
    rst = 0; cfg_on = 1;
    cyc();
    exp_acc = 0;

    // R1 table walk
    for (int i = 0; i < 6; i++) begin
      rx_char_stb = VEC[i][17]; rx_char = VEC[i][16:9];
      tx_char_stb = VEC[i][8];  tx_char = VEC[i][7:0];
      if (VEC[i][17]) exp_acc = exp_acc ^ VEC[i][16:9];
      if (VEC[i][8])  exp_acc = exp_acc ^ VEC[i][7:0];
      cyc();
      check($sformatf("R1 vector %0d", i), lrc_value, exp_acc);
      quiet();
    end

    // R2 switch-off with a strobe
    cfg_on = 0; rx_char_stb = 1; rx_char = 8'h5A;
    cyc(); quiet();
    check("R2 off clears", lrc_value, 0);
    rx_block_end = 1; tx_char_stb = 1; tx_char = 8'h11;
    cyc(); quiet();
    check("R2 off holds zero", lrc_value, 0);
    check("R2 off ignores block end", rx_good, 0);
    cfg_on = 1;
    cyc();

    // R3 block check with same-cycle char
    rx_char_stb = 1; rx_char = 8'h12; cyc(); quiet();
    rx_char_stb = 1; rx_char = 8'h34; cyc(); quiet();
    rx_char_stb = 1; rx_char = 8'h26; rx_block_end = 1; cyc(); quiet();
    check("R3 zero block sets good", rx_good, 1);
    rx_block_start = 1; cyc(); quiet();
    check("R4 block start clears good", rx_good, 0);
    rx_block_end = 1; cyc(); quiet();
    check("R3 zero acc sets good", rx_good, 1);
    sw_clr_good = 1; cyc(); quiet();
    check("R4 sw clear", rx_good, 0);
    rx_block_end = 1; cyc(); quiet();
    rx_char_stb = 1; rx_char = 8'h01; rx_block_end = 1; cyc(); quiet();
    check("R3 nonzero block", rx_good, 0);
    rx_char_stb = 1; rx_char = 8'h01; rx_block_end = 1; sw_clr_good = 1; cyc(); quiet();
    check("R4 end beats clear", rx_good, 1);

    // R8 / R9 transmitter enable rise with strobe
    tx_char_stb = 1; tx_char = 8'hA5; cyc(); quiet();
    check("R1 tx fold", lrc_value, 8'hA5);
    tx_en = 1; tx_char_stb = 1; tx_char = 8'h0F; cyc(); quiet();
    check("R8 R9 tx_en rise clears", lrc_value, 0);

    // R5 / R6 auto-append
    cfg_append = 1; fifo_empty = 0; cyc();
    tx_char_stb = 1; tx_char = 8'h11; cyc(); quiet();
    tx_char_stb = 1; tx_char = 8'h22; cyc(); quiet();
    fifo_empty = 1; tx_char_stb = 1; tx_char = 8'h44; cyc(); quiet();
    check("R5 offer raised", chk_valid, 1);
    check("R5 offer data", chk_data, 8'h77);
    cyc(); cyc();
    check("R5 offer held", chk_valid, 1);
    check("R5 data held", chk_data, 8'h77);
    chk_ready = 1; cyc(); chk_ready = 0;
    check("R6 offer dropped", chk_valid, 0);
    check("R6 acc cleared", lrc_value, 0);
    cyc(); cyc();
    check("R6 single offer", chk_valid, 0);

    // R7 drain without append
    cfg_append = 0; fifo_empty = 0; cyc();
    tx_char_stb = 1; tx_char = 8'h3C; cyc(); quiet();
    check("R1 pre-drain", lrc_value, 8'h3C);
    fifo_empty = 1; cyc();
    check("R7 drain clears", lrc_value, 0);
    check("R7 no offer", chk_valid, 0);

    // R9 end-of-transmission beats strobe
    fifo_empty = 0; tx_char_stb = 1; tx_char = 8'h55; cyc(); quiet();
    fifo_empty = 1; rx_char_stb = 1; rx_char = 8'h0A; cyc(); quiet();
    check("R9 drain beats strobe", lrc_value, 0);

    // R10 mid-run reset
    rx_char_stb = 1; rx_char = 8'h9C; cyc(); quiet();
    rx_block_end = 1; rx_char_stb = 1; rx_char = 8'h9C; cyc(); quiet();
    rst = 1; cyc(); rst = 0;
    check("R10 mid reset lrc", lrc_value, 0);
    check("R10 mid reset good", rx_good, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule